// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single DMA channel. Software loads a source address, a destination address, a unit count and a control word through a small register port. The channel then moves data one unit at a time over a valid/ready memory port until the count is exhausted. Each unit is either a read from the source followed by a write of that data to the destination, or a single read at the source only. After each unit both addresses may step up, step down or stay put, by the unit size. A unit starts on an automatic request, on a request pin, or on a request line from an on-chip peripheral.

Work proceeds only while five conditions all hold: the channel enable is set, the global enable is set, and the done flag, the NMI flag and the address-error flag are all clear. When the count reaches zero the done flag is set, and an interrupt is raised if it is enabled. A misaligned address, an error response from the bus, an NMI pulse, or software clearing either enable stops the channel at once. The unit that was in flight is dropped, and the count and addresses keep their values. In cycle-steal mode the channel gives the bus up after every unit. In burst mode it keeps the bus from the first unit to the last.

Top module: `dma_channel_seq`

## Requirements
- R1: Register port: cfg_sel 0 source address, 1 destination address, 2 count, 3 control, 4 global. Control bits are [0] channel enable, [1] done flag, [2] interrupt enable, [3] burst, [4] single address, [6:5] unit size, [8:7] request source, [10:9] source step mode, [12:11] destination step mode. Global bits are [0] global enable, [1] NMI flag, [2] address-error flag. cfg_rdata shows the selected register at once. No access is issued unless channel enable=1, global enable=1 and the done, NMI and address-error flags are all 0.
- R2: Request source 0 starts units with no request input. Source 1 uses req_ext and source 2 uses req_periph. A request line that is not selected has no effect.
- R3: In dual address mode a unit is a read at the source address, then a write at the destination address whose data is the read data. dack is high for one cycle as the unit completes, and the count drops by 1.
- R4: In single address mode a unit is one read at the source address. The destination address is neither accessed nor changed.
- R5: When the count goes from 1 to 0 the done flag is set and no further unit starts. irq is high while both the done flag and the interrupt enable are 1. Writing the control word with the done flag 0 clears it.
- R6: Step mode 0 keeps an address fixed, 1 adds the unit size and 2 subtracts it, once per completed unit. Unit size code 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. mem_size carries the code.
- R7: If the source address, or in dual mode the destination address, is not a multiple of the unit size when a unit starts, the address-error flag is set and no access is issued. The alignment of the destination address has no effect in single mode.
- R8: An error response on any access sets the address-error flag and drops the unit. The count and addresses keep their values, and mem_valid is low in the next cycle. After software clears the flag, work resumes from the same addresses.
- R9: An nmi pulse sets the NMI flag, and mem_valid is low from the next cycle on.
- R10: A write that clears the channel enable or the global enable makes mem_valid low in the next cycle, and the count keeps its value.
- R11: In cycle-steal mode bus_own falls after every unit, and each unit needs its own request. In burst mode a single request runs all units, with bus_own held high throughout.
- R12: After reset all registers read 0, and mem_valid, bus_own, dack and irq are low.
- R13: With a count of 0 no access is issued and the done flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Selected register value |
| req_ext | input | 1 | Request pin |
| req_periph | input | 1 | On-chip peripheral request |
| nmi | input | 1 | NMI event pulse |
| mem_valid | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_err | input | 1 | Error response, valid with mem_ready |
| bus_own | output | 1 | Channel holds the bus |
| dack | output | 1 | Unit completed pulse |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
A wrong step or count register shows at the ports on the very next access, as an address the bench did not predict in its access log. It also shows a few cycles after the end, as a wrong final readback. A flag stuck at the wrong value shows within a cycle, either as an access that should not appear or as one that never comes, so the bench watches mem_valid in the cycle after each abort stimulus. A wrong choice between releasing and holding the bus shows as a count of bus_own falls that differs from the number of units.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] rsel;
        logic [1:0] usize;
        logic       single;
        logic       burst;
        logic       ie;
        logic       te;
        logic       de;
    } chctl_t;

    localparam int CTLW = $bits(chctl_t);

    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_DST = 3'd1;
    localparam logic [2:0] SEL_CNT = 3'd2;
    localparam logic [2:0] SEL_CTL = 3'd3;
    localparam logic [2:0] SEL_GLB = 3'd4;

    localparam logic [1:0] RQ_AUTO   = 2'd0;
    localparam logic [1:0] RQ_PIN    = 2'd1;
    localparam logic [1:0] RQ_PERIPH = 2'd2;

    localparam logic [1:0] AM_INC = 2'd1;
    localparam logic [1:0] AM_DEC = 2'd2;

endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
    import dmaseq_pkg::*;
(
    input  logic [1:0] rsel_i,
    input  logic       pin_req_i,
    input  logic       periph_req_i,
    output logic       req_o
);

    always_comb begin
        case (rsel_i)
            RQ_AUTO:   req_o = 1'b1;
            RQ_PIN:    req_o = pin_req_i;
            RQ_PERIPH: req_o = periph_req_i;
            default:   req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dmaseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    size_i,
    output logic [AW-1:0] next_o,
    output logic          misal_o
);

    logic [AW-1:0] bytes;

    always_comb begin
        case (size_i)
            2'd0:    bytes = AW'(1);
            2'd1:    bytes = AW'(2);
            default: bytes = AW'(4);
        endcase
    end

    always_comb begin
        case (size_i)
            2'd0:    misal_o = 1'b0;
            2'd1:    misal_o = addr_i[0];
            default: misal_o = |addr_i[1:0];
        endcase
    end

    always_comb begin
        case (mode_i)
            AM_INC:  next_o = addr_i + bytes;
            AM_DEC:  next_o = addr_i - bytes;
            default: next_o = addr_i;
        endcase
    end

endmodule

// File: rtl/dma_channel_seq.sv
module dma_channel_seq
    import dmaseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          req_ext,
    input  logic          req_periph,
    input  logic          nmi,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          bus_own,
    output logic          dack,
    output logic          irq
);

    localparam int NPTR = 2;

    typedef struct packed {
        logic [AW-1:0] sar;
        logic [AW-1:0] dar;
        logic [CW-1:0] cnt;
        chctl_t        ctl;
        logic          dme;
        logic          nmif;
        logic          ae;
        seq_st_e       st;
        logic [DW-1:0] hold;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic          req_sel;
    logic          run_en;
    logic          start_ok;
    logic          bad_align;
    logic          last_unit;
    logic          unit_done;
    logic [AW-1:0] cur_addr [NPTR];
    logic [1:0]    cur_mode [NPTR];
    logic [AW-1:0] nxt_addr [NPTR];
    logic          misal    [NPTR];

    dma_req_sel u_req_sel (
        .rsel_i       (r_q.ctl.rsel),
        .pin_req_i    (req_ext),
        .periph_req_i (req_periph),
        .req_o        (req_sel)
    );

    assign cur_addr[0] = r_q.sar;
    assign cur_addr[1] = r_q.dar;
    assign cur_mode[0] = r_q.ctl.smode;
    assign cur_mode[1] = r_q.ctl.dmode;

    for (genvar g = 0; g < NPTR; g++) begin : g_step
        dma_addr_step #(.AW(AW)) u_step (
            .addr_i  (cur_addr[g]),
            .mode_i  (cur_mode[g]),
            .size_i  (r_q.ctl.usize),
            .next_o  (nxt_addr[g]),
            .misal_o (misal[g])
        );
    end

    assign run_en    = r_q.ctl.de & r_q.dme & ~r_q.ctl.te & ~r_q.nmif & ~r_q.ae;
    assign start_ok  = run_en & (r_q.cnt != '0) & req_sel;
    assign bad_align = misal[0] | (~r_q.ctl.single & misal[1]);
    assign last_unit = (r_q.cnt == CW'(1));

    always_comb begin
        r_d       = r_q;
        unit_done = 1'b0;

        if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC: r_d.sar = cfg_wdata;
                SEL_DST: r_d.dar = cfg_wdata;
                SEL_CNT: r_d.cnt = cfg_wdata[CW-1:0];
                SEL_CTL: r_d.ctl = chctl_t'(cfg_wdata[CTLW-1:0]);
                SEL_GLB: begin
                    r_d.dme  = cfg_wdata[0];
                    r_d.nmif = cfg_wdata[1];
                    r_d.ae   = cfg_wdata[2];
                end
                default: ;
            endcase
        end

        if (nmi) begin
            r_d.nmif = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d.st = ST_RD;
                end
            end
            ST_RD: begin
                if (!run_en) begin
                    r_d.st = ST_IDLE;
                end else if (bad_align) begin
                    r_d.ae = 1'b1;
                    r_d.st = ST_IDLE;
                end else if (mem_ready) begin
                    if (mem_err) begin
                        r_d.ae = 1'b1;
                        r_d.st = ST_IDLE;
                    end else if (r_q.ctl.single) begin
                        unit_done = 1'b1;
                    end else begin
                        r_d.hold = mem_rdata;
                        r_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (!run_en) begin
                    r_d.st = ST_IDLE;
                end else if (mem_ready) begin
                    if (mem_err) begin
                        r_d.ae = 1'b1;
                        r_d.st = ST_IDLE;
                    end else begin
                        unit_done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (unit_done) begin
            r_d.cnt = r_q.cnt - 1'b1;
            r_d.sar = nxt_addr[0];
            if (!r_q.ctl.single) begin
                r_d.dar = nxt_addr[1];
            end
            if (last_unit) begin
                r_d.ctl.te = 1'b1;
                r_d.st     = ST_IDLE;
            end else if (r_q.ctl.burst) begin
                r_d.st = ST_RD;
            end else begin
                r_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (cfg_sel)
            SEL_SRC: cfg_rdata = r_q.sar;
            SEL_DST: cfg_rdata = r_q.dar;
            SEL_CNT: cfg_rdata = AW'(r_q.cnt);
            SEL_CTL: cfg_rdata = AW'(r_q.ctl);
            SEL_GLB: cfg_rdata = AW'({r_q.ae, r_q.nmif, r_q.dme});
            default: cfg_rdata = '0;
        endcase
    end

    assign mem_valid = run_en & (((r_q.st == ST_RD) & ~bad_align) | (r_q.st == ST_WR));
    assign mem_we    = (r_q.st == ST_WR);
    assign mem_addr  = (r_q.st == ST_WR) ? r_q.dar : r_q.sar;
    assign mem_size  = r_q.ctl.usize;
    assign mem_wdata = r_q.hold;
    assign bus_own   = (r_q.st != ST_IDLE);
    assign dack      = unit_done;
    assign irq       = r_q.ctl.te & r_q.ctl.ie;

    AST_DE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_CTL && !cfg_wdata[0]) |=> !mem_valid); // R10
    AST_DME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_GLB && !cfg_wdata[0]) |=> !mem_valid); // R10
    AST_NMI_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !mem_valid); // R9
    AST_BERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_err) |=> !mem_valid); // R8
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_size == 2'd0) || (mem_size == 2'd1 && !mem_addr[0]) ||
                       (mem_size[1] && mem_addr[1:0] == 2'b00))); // R7
    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !(cfg_we && cfg_sel == SEL_CNT)) |=> (r_q.cnt == $past(r_q.cnt) - 1'b1)); // R3
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !r_q.ctl.burst) |=> !bus_own); // R11
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(dack) || $past(cfg_we))); // R5

endmodule

// File: tb/test_dma_channel_seq.sv
module test_dma_channel_seq;

    localparam logic [2:0] R_SRC = 3'd0, R_DST = 3'd1, R_CNT = 3'd2, R_CTL = 3'd3, R_GLB = 3'd4;
    localparam int NV = 6;
    // size, smode, dmode, single, burst, count, src, dst
    localparam logic [79:0] VECS [NV] = '{
        {2'd2, 2'd1, 2'd1, 1'b0, 1'b0, 8'd3, 32'h0000_1000, 32'h0000_2000},
        {2'd1, 2'd2, 2'd0, 1'b0, 1'b1, 8'd4, 32'h0000_1106, 32'h0000_3000},
        {2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 8'd2, 32'h0000_1203, 32'h0000_4001},
        {2'd2, 2'd1, 2'd1, 1'b1, 1'b1, 8'd3, 32'h0000_1300, 32'h0000_5000},
        {2'd0, 2'd2, 2'd1, 1'b1, 1'b0, 8'd5, 32'h0000_1405, 32'h0000_6000},
        {2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 8'd1, 32'h0000_1500, 32'h0000_7002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_ext = 1'b0;
    logic        req_periph = 1'b0;
    logic        nmi = 1'b0;
    logic        mem_valid, mem_we, mem_ready, mem_err, bus_own, dack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        stall = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_log   = 0;
    int n_dack  = 0;
    int n_fall  = 0;
    logic        own_prev = 1'b0;
    logic        log_we   [64];
    logic [31:0] log_addr [64];
    logic [31:0] log_wd   [64];

    always #4 clk = ~clk;

    dma_channel_seq i_dma_channel_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_ext(req_ext),
        .req_periph(req_periph), .nmi(nmi), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .bus_own(bus_own), .dack(dack), .irq(irq)
    );

    assign mem_ready = mem_valid & ~stall;
    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
    assign mem_err   = err_en && (mem_addr == err_addr);

    always @(negedge clk) begin
        if (mem_valid && mem_ready && !mem_err && n_log < 64) begin
            log_we[n_log]   = mem_we;
            log_addr[n_log] = mem_addr;
            log_wd[n_log]   = mem_wdata;
            n_log++;
        end
        if (dack) n_dack++;
        if (own_prev && !bus_own) n_fall++;
        own_prev = bus_own;
    end

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): act=%0d exp=%0d", 0, 1);
        finish_up();
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_sel = s;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        cfg_sel = s;
        #1;
        v = cfg_rdata;
    endtask

    task automatic clear_mon();
        n_log = 0;
        n_dack = 0;
        n_fall = 0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_dack(input int n);
        for (int i = 0; i < 600 && n_dack < n; i++) @(negedge clk);
        idle_cycles(3);
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 50 && !mem_valid; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_ctl(input logic de, input logic ie, input logic burst,
                                           input logic single, input logic [1:0] size,
                                           input logic [1:0] rsel, input logic [1:0] sm,
                                           input logic [1:0] dm);
        return {19'd0, dm, sm, rsel, size, single, burst, ie, 1'b0, de};
    endfunction

    function automatic logic [31:0] stp(input logic [1:0] mode, input logic [1:0] size);
        logic [31:0] b;
        b = (size == 2'd0) ? 32'd1 : (size == 2'd1) ? 32'd2 : 32'd4;
        if (mode == 2'd1) return b;
        if (mode == 2'd2) return -b;
        return 32'd0;
    endfunction

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr(R_CTL, 32'd0);
        wr(R_GLB, 32'd1);
        wr(R_SRC, s);
        wr(R_DST, d);
        wr(R_CNT, c);
        clear_mon();
    endtask

    logic [31:0] v;

    initial begin
        idle_cycles(3);
        // R12 reset state
        rd(R_SRC, v); check(v == 0, "R12 src reset", v, 0);
        rd(R_CNT, v); check(v == 0, "R12 cnt reset", v, 0);
        rd(R_CTL, v); check(v == 0, "R12 ctl reset", v, 0);
        rd(R_GLB, v); check(v == 0, "R12 glb reset", v, 0);
        check({mem_valid, bus_own, dack, irq} == 4'b0, "R12 outputs reset",
              {28'd0, mem_valid, bus_own, dack, irq}, 0);
        rst_n = 1'b1;
        idle_cycles(2);

        // main vector table, auto request, ie=1
        for (int vi = 0; vi < NV; vi++) begin
            logic [1:0]  sz, sm, dm;
            logic        sg, bu;
            logic [7:0]  cn;
            logic [31:0] sa0, da0, ss, ds, sa, da;
            int          bad, expn;
            {sz, sm, dm, sg, bu, cn, sa0, da0} = VECS[vi];
            ss = stp(sm, sz);
            ds = stp(dm, sz);
            setup(sa0, da0, {24'd0, cn});
            wr(R_CTL, mk_ctl(1'b1, 1'b1, bu, sg, sz, 2'd0, sm, dm));
            wait_dack(int'(cn));
            expn = sg ? int'(cn) : 2 * int'(cn);
            bad = 0;
            for (int k = 0; k < int'(cn); k++) begin
                sa = sa0 + 32'(k) * ss;
                da = da0 + 32'(k) * ds;
                if (sg) begin
                    if (log_we[k] !== 1'b0 || log_addr[k] !== sa) bad++;
                end else begin
                    if (log_we[2*k] !== 1'b0 || log_addr[2*k] !== sa) bad++;
                    if (log_we[2*k+1] !== 1'b1 || log_addr[2*k+1] !== da ||
                        log_wd[2*k+1] !== (sa ^ 32'h5A5A_0000)) bad++;
                end
            end
            check(n_log == expn, sg ? "R4 access count" : "R3 access count", n_log, expn);
            check(bad == 0, sg ? "R4 R6 access log" : "R3 R6 access log", bad, 0);
            check(n_dack == int'(cn), "R3 dack pulses", n_dack, {24'd0, cn});
            rd(R_SRC, v); check(v == sa0 + {24'd0, cn} * ss, "R6 final src", v, sa0 + {24'd0, cn} * ss);
            rd(R_DST, v);
            if (sg) check(v == da0, "R4 dst unchanged", v, da0);
            else    check(v == da0 + {24'd0, cn} * ds, "R6 final dst", v, da0 + {24'd0, cn} * ds);
            rd(R_CNT, v); check(v == 0, "R5 count zero", v, 0);
            rd(R_CTL, v); check(v[1] == 1'b1, "R5 done flag", {31'd0, v[1]}, 1);
            check(irq == 1'b1, "R5 irq", {31'd0, irq}, 1);
            check(n_fall == (bu ? 1 : int'(cn)), "R11 bus release count", n_fall, bu ? 1 : {24'd0, cn});
        end

        // R5 irq masked, done flag cleared by write
        setup(32'h100, 32'h200, 32'd1);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        wait_dack(1);
        check(irq == 1'b0, "R5 irq masked", {31'd0, irq}, 0);
        wr(R_CTL, 32'd0);
        rd(R_CTL, v); check(v[1] == 1'b0, "R5 done cleared", {31'd0, v[1]}, 0);

        // R1 global enable off blocks, then on starts
        setup(32'h800, 32'h900, 32'd2);
        wr(R_GLB, 32'd0);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        idle_cycles(20);
        check(n_log == 0, "R1 no access without global enable", n_log, 0);
        wr(R_GLB, 32'd1);
        wait_dack(2);
        check(n_log == 4, "R1 access after enable", n_log, 4);
        // R1 address-error flag set by software blocks
        setup(32'h800, 32'h900, 32'd2);
        wr(R_GLB, 32'd5);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        idle_cycles(20);
        check(n_log == 0, "R1 no access with error flag", n_log, 0);

        // R13 count zero
        setup(32'h800, 32'h900, 32'd0);
        wr(R_CTL, mk_ctl(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        idle_cycles(20);
        check(n_log == 0, "R13 no access for zero count", n_log, 0);
        rd(R_CTL, v); check(v[1] == 1'b0, "R13 done stays clear", {31'd0, v[1]}, 0);

        // R2 pin request, cycle steal, one request per unit (R11)
        setup(32'hA00, 32'hB00, 32'd3);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 2'd1, 2'd1));
        req_periph = 1'b1;
        idle_cycles(20);
        check(n_log == 0, "R2 unselected request ignored", n_log, 0);
        req_periph = 1'b0;
        req_ext = 1'b1;
        for (int i = 0; i < 50 && !dack; i++) @(negedge clk);
        req_ext = 1'b0;
        idle_cycles(20);
        rd(R_CNT, v); check(v == 2, "R11 one unit per request", v, 2);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, 2'd1, 2'd1));
        req_periph = 1'b1;
        wait_dack(3);
        req_periph = 1'b0;
        rd(R_CNT, v); check(v == 0, "R2 peripheral request", v, 0);

        // R11 burst with one pin pulse
        setup(32'hC00, 32'hD00, 32'd3);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 2'd1, 2'd1));
        req_ext = 1'b1;
        @(negedge clk);
        req_ext = 1'b0;
        wait_dack(3);
        check(n_log == 6, "R11 burst runs all units", n_log, 6);
        check(n_fall == 1, "R11 burst holds bus", n_fall, 1);

        // R7 misaligned source
        setup(32'h1002, 32'h2000, 32'd2);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        idle_cycles(10);
        rd(R_GLB, v); check(v[2] == 1'b1, "R7 error flag", {31'd0, v[2]}, 1);
        check(n_log == 0, "R7 no access", n_log, 0);
        rd(R_CNT, v); check(v == 2, "R7 count kept", v, 2);
        // R7 misaligned destination, dual
        setup(32'h1000, 32'h2001, 32'd1);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1));
        idle_cycles(10);
        rd(R_GLB, v); check(v[2] == 1'b1, "R7 dst misaligned dual", {31'd0, v[2]}, 1);
        // R7 misaligned destination ignored in single mode
        setup(32'h1000, 32'h2003, 32'd1);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd1, 2'd1));
        wait_dack(1);
        rd(R_GLB, v); check(v[2] == 1'b0, "R7 single ignores dst", {31'd0, v[2]}, 0);
        check(n_log == 1, "R7 single completes", n_log, 1);

        // R8 bus error on first write, then resume
        err_en = 1'b1;
        err_addr = 32'h2400;
        setup(32'h2300, 32'h2400, 32'd2);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        idle_cycles(10);
        rd(R_GLB, v); check(v[2] == 1'b1, "R8 error flag", {31'd0, v[2]}, 1);
        check(n_log == 1, "R8 unit dropped", n_log, 1);
        rd(R_CNT, v); check(v == 2, "R8 count kept", v, 2);
        rd(R_SRC, v); check(v == 32'h2300, "R8 src kept", v, 32'h2300);
        err_en = 1'b0;
        clear_mon();
        wr(R_GLB, 32'd1);
        wait_dack(2);
        check(n_log == 4 && log_addr[1] == 32'h2400 && log_addr[2] == 32'h2304,
              "R8 resume same addresses", log_addr[2], 32'h2304);

        // R9 NMI abort during a stalled access
        stall = 1'b1;
        setup(32'h3000, 32'h3100, 32'd2);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        wait_valid();
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        check(mem_valid == 1'b0, "R9 access dropped", {31'd0, mem_valid}, 0);
        rd(R_GLB, v); check(v[1] == 1'b1, "R9 nmi flag", {31'd0, v[1]}, 1);
        stall = 1'b0;
        idle_cycles(10);
        check(n_log == 0, "R9 no further access", n_log, 0);

        // R10 clearing channel enable
        stall = 1'b1;
        setup(32'h3000, 32'h3100, 32'd2);
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        wait_valid();
        wr(R_CTL, mk_ctl(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        check(mem_valid == 1'b0, "R10 channel enable abort", {31'd0, mem_valid}, 0);
        rd(R_CNT, v); check(v == 2, "R10 count kept", v, 2);
        // R10 clearing global enable
        wr(R_CTL, mk_ctl(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 2'd1, 2'd1));
        wait_valid();
        wr(R_GLB, 32'd0);
        check(mem_valid == 1'b0, "R10 global enable abort", {31'd0, mem_valid}, 0);
        stall = 1'b0;
        idle_cycles(10);
        check(n_log == 0, "R10 no access after abort", n_log, 0);

        finish_up();
    end

endmodule